// File: doc/BRIEF.md
# Linked-Group String Memory Controller

This block keeps data of any length in fixed-size groups of on-chip storage and chains those groups together in hardware. A client unit sends one request at a time through a valid/ready port. Each request carries an opcode, a word address and a data word. The response arrives as a single-cycle pulse with an address, a read word and an error flag. The client never handles a link. It obtains a starting address with an allocate request. It then writes or reads word after word, each time using the address the controller handed back. When a group fills up or runs out, the controller moves on to the next group by itself.

Storage is made of pages, and each page holds 28 groups of 8 words of 64 bits. Pages are consumed from a free-page pool that is a simple counter. The first time a group is needed from a page, that page is carved into the free-group list. Each group has three records: a forward link, a backward link and a count of the words written to it. Groups that a delete request returns go back onto the front of the free-group list.

Top module: `lgm_ctrl`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` is 0.
- R2: An address is {page[1:0], group[4:0], word[2:0]}. All ones (0x3FF) is the null address. Allocate (opcode 0) answers with word 0 of a free group. Just after reset the first two allocations return 0x000 and then 0x008.
- R3: If the free-group list is empty when a group is needed, the controller carves the next unused page. While it does so, `req_ready` stays low for 30 cycles in total, and the response comes 30 cycles after acceptance. Without a carve, the response comes one cycle after acceptance.
- R4: Store (opcode 1) to a word below 7 writes the data and answers with the request address plus one.
- R5: Store to word 7 writes the data, allocates a new group, links it forward from the old group and backward to it, and answers with word 0 of the new group.
- R6: Fetch (opcode 2) returns the stored word together with the address of the next written word. At word 7 that next address is word 0 of the forward-linked group.
- R7: Fetch answers with the null address when the word it read is the last written word of the chain. This also holds when the next group exists but has had no word written to it.
- R8: Delete (opcode 3) may be given any address in a chain. It walks backward to the first group and then frees every group from there forward. It answers with no error once the last group is freed. Freed groups are handed out again last-freed-first.
- R9: If a group is needed and both the group list and the page pool are empty, the response has `rsp_err` = 1 and the null address, and nothing is changed: the store data is not written and the word count is not updated.
- R10: `rsp_valid` is high for exactly one cycle per request, and `req_ready` is low from acceptance until that response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_op | input | 2 | 0 allocate, 1 store, 2 fetch, 3 delete |
| req_addr | input | 10 | Word address {page, group, word} |
| req_wdata | input | 64 | Data word for store |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Out of storage |
| rsp_addr | output | 10 | Returned address, null when none |
| rsp_rdata | output | 64 | Word read by fetch, zero otherwise |

## Verification
A corrupted forward link or word count first shows up on a fetch walk. The returned next address jumps to the wrong group, or it turns null too early or too late, and the bench sees this on the very response that crosses the damaged boundary. A damaged free-list head or backward link shows up through allocation order. After a delete, the next two allocations must return the freed groups in reverse order. An off-by-one in the page pool becomes visible as a wrong count of successful allocations before the error. It also shows as carve latency at the wrong requests.

// File: rtl/lgm_pkg.sv
// Shared types for the linked-group memory controller.
package lgm_pkg;
    typedef enum logic [1:0] {
        OP_ALLOC = 2'd0,
        OP_STORE = 2'd1,
        OP_FETCH = 2'd2,
        OP_DEL   = 2'd3
    } lgm_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXEC,
        ST_CARVE,
        ST_BACK,
        ST_FREE
    } lgm_state_e;
endpackage

// File: rtl/lgm_word_store.sv
// Word storage for all groups, addressed by {group index, word}.
// Assumes: one write port, combinational read; out-of-range reads give zero.
module lgm_word_store #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 896,
    parameter int AW     = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Write one word when enabled.
    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;
    end

    // Guarded combinational read.
    always_comb rdata = (int'(raddr) < DEPTH) ? mem[raddr] : '0;
endmodule

// File: rtl/lgm_link_table.sv
// Per-group records: forward link, backward link, free-list link, word count.
// Assumes: each record has one write port; port A reads a chain group,
// port B reads the free-list head or a forward neighbour.
module lgm_link_table #(
    parameter int NUM_GROUPS = 112,
    parameter int GA_W       = 7,
    parameter int FILL_W     = 4
) (
    input  logic              clk,
    input  logic [GA_W-1:0]   a_idx,
    output logic [GA_W-1:0]   a_fwd,
    output logic [GA_W-1:0]   a_bwd,
    output logic [FILL_W-1:0] a_fill,
    input  logic [GA_W-1:0]   b_idx,
    output logic [GA_W-1:0]   b_nxt,
    output logic [FILL_W-1:0] b_fill,
    input  logic              fwd_we,
    input  logic [GA_W-1:0]   fwd_idx,
    input  logic [GA_W-1:0]   fwd_val,
    input  logic              bwd_we,
    input  logic [GA_W-1:0]   bwd_idx,
    input  logic [GA_W-1:0]   bwd_val,
    input  logic              fill_we,
    input  logic [GA_W-1:0]   fill_idx,
    input  logic [FILL_W-1:0] fill_val,
    input  logic              nxt_we,
    input  logic [GA_W-1:0]   nxt_idx,
    input  logic [GA_W-1:0]   nxt_val
);
    logic [GA_W-1:0]   fwd_mem  [NUM_GROUPS];
    logic [GA_W-1:0]   bwd_mem  [NUM_GROUPS];
    logic [GA_W-1:0]   nxt_mem  [NUM_GROUPS];
    logic [FILL_W-1:0] fill_mem [NUM_GROUPS];

    logic a_ok, b_ok;

    // Update whichever records are enabled this cycle.
    always_ff @(posedge clk) begin
        if (fwd_we  && int'(fwd_idx)  < NUM_GROUPS) fwd_mem[fwd_idx]   <= fwd_val;
        if (bwd_we  && int'(bwd_idx)  < NUM_GROUPS) bwd_mem[bwd_idx]   <= bwd_val;
        if (fill_we && int'(fill_idx) < NUM_GROUPS) fill_mem[fill_idx] <= fill_val;
        if (nxt_we  && int'(nxt_idx)  < NUM_GROUPS) nxt_mem[nxt_idx]   <= nxt_val;
    end

    // Guarded combinational reads; an out-of-range index reads as null/zero.
    always_comb begin
        a_ok   = int'(a_idx) < NUM_GROUPS;
        b_ok   = int'(b_idx) < NUM_GROUPS;
        a_fwd  = a_ok ? fwd_mem[a_idx]  : '1;
        a_bwd  = a_ok ? bwd_mem[a_idx]  : '1;
        a_fill = a_ok ? fill_mem[a_idx] : '0;
        b_nxt  = b_ok ? nxt_mem[b_idx]  : '1;
        b_fill = b_ok ? fill_mem[b_idx] : '0;
    end
endmodule

// File: rtl/lgm_page_pool.sv
// Free-page pool and page carving sequencer.
// Assumes: pages are taken in ascending order and never returned; a carve
// visits groups from the highest down to zero so the list pops in ascending order.
module lgm_page_pool #(
    parameter int NUM_PAGES       = 4,
    parameter int GROUPS_PER_PAGE = 28,
    parameter int P_W             = 2,
    parameter int G_W             = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    output logic               page_avail,
    output logic [P_W+G_W-1:0] carve_ga,
    output logic               carve_last
);
    localparam int CNT_W = $clog2(NUM_PAGES + 1);
    localparam logic [G_W-1:0] TOP_G = G_W'(GROUPS_PER_PAGE - 1);

    logic [CNT_W-1:0] used_q;
    logic [G_W-1:0]   grp_q;

    // Advance through the groups of the page being carved.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q <= '0;
            grp_q  <= TOP_G;
        end else if (step) begin
            if (grp_q == '0) begin
                used_q <= used_q + 1'b1;
                grp_q  <= TOP_G;
            end else begin
                grp_q <= grp_q - 1'b1;
            end
        end
    end

    // Present the current carve position and remaining capacity.
    always_comb begin
        page_avail = int'(used_q) < NUM_PAGES;
        carve_ga   = {P_W'(used_q), grp_q};
        carve_last = grp_q == '0;
    end
endmodule

// File: rtl/lgm_ctrl.sv
// Linked-group memory controller top: decodes requests and runs allocation,
// chained store, link-following fetch and chain delete.
// Assumes: one outstanding request; GROUPS_PER_PAGE < 2**G_W so the all-ones
// group address never names a real group; WORDS_PER_GROUP is a power of two.
module lgm_ctrl
    import lgm_pkg::*;
#(
    parameter int DATA_W          = 64,
    parameter int NUM_PAGES       = 4,
    parameter int GROUPS_PER_PAGE = 28,
    parameter int WORDS_PER_GROUP = 8,
    localparam int W_W = $clog2(WORDS_PER_GROUP),
    localparam int G_W = $clog2(GROUPS_PER_PAGE),
    localparam int P_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
    localparam int A_W = P_W + G_W + W_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [A_W-1:0]    req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [A_W-1:0]    rsp_addr,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int GA_W       = P_W + G_W;
    localparam int FILL_W     = W_W + 1;
    localparam int NUM_GROUPS = NUM_PAGES * GROUPS_PER_PAGE;
    localparam int DEPTH      = NUM_GROUPS * WORDS_PER_GROUP;
    localparam logic [GA_W-1:0]   G_NULL = '1;
    localparam logic [A_W-1:0]    A_NULL = '1;
    localparam logic [W_W-1:0]    LAST_W = '1;
    localparam logic [FILL_W-1:0] FULL   = FILL_W'(WORDS_PER_GROUP);

    function automatic logic [GA_W-1:0] to_idx(input logic [GA_W-1:0] ga);
        return GA_W'(int'(ga[GA_W-1:G_W]) * GROUPS_PER_PAGE + int'(ga[G_W-1:0]));
    endfunction

    lgm_state_e        state_q, state_d;
    lgm_op_e           op_q;
    logic [A_W-1:0]    addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [GA_W-1:0]   head_q, head_d, walk_q, walk_d;
    logic              rv_d, re_d;
    logic [A_W-1:0]    ra_d;
    logic [DATA_W-1:0] rd_d;

    logic [GA_W-1:0]   cur_ga, a_ga, b_ga, a_fwd, a_bwd, b_nxt;
    logic [FILL_W-1:0] a_fill, b_fill, w_next;
    logic [W_W-1:0]    word_q;
    logic              head_null, fwd_live, step, page_avail, carve_last;
    logic [GA_W-1:0]   carve_ga;
    logic              fwd_we, bwd_we, fill_we, nxt_we, data_we;
    logic [GA_W-1:0]   fwd_idx, fwd_val, bwd_idx, bwd_val, fill_idx, nxt_idx, nxt_val;
    logic [FILL_W-1:0] fill_val;
    logic [DATA_W-1:0] mem_rdata;

    lgm_word_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(GA_W + W_W)) store_i (
        .clk(clk), .we(data_we), .waddr({to_idx(a_ga), word_q}), .wdata(wdata_q),
        .raddr({to_idx(a_ga), word_q}), .rdata(mem_rdata)
    );

    lgm_link_table #(.NUM_GROUPS(NUM_GROUPS), .GA_W(GA_W), .FILL_W(FILL_W)) links_i (
        .clk(clk), .a_idx(to_idx(a_ga)), .a_fwd(a_fwd), .a_bwd(a_bwd), .a_fill(a_fill),
        .b_idx(to_idx(b_ga)), .b_nxt(b_nxt), .b_fill(b_fill),
        .fwd_we(fwd_we), .fwd_idx(fwd_idx), .fwd_val(fwd_val),
        .bwd_we(bwd_we), .bwd_idx(bwd_idx), .bwd_val(bwd_val),
        .fill_we(fill_we), .fill_idx(fill_idx), .fill_val(fill_val),
        .nxt_we(nxt_we), .nxt_idx(nxt_idx), .nxt_val(nxt_val)
    );

    lgm_page_pool #(.NUM_PAGES(NUM_PAGES), .GROUPS_PER_PAGE(GROUPS_PER_PAGE),
                    .P_W(P_W), .G_W(G_W)) pool_i (
        .clk(clk), .rst_n(rst_n), .step(step), .page_avail(page_avail),
        .carve_ga(carve_ga), .carve_last(carve_last)
    );

    // Select which groups the two link-table read ports look at.
    always_comb begin
        cur_ga    = addr_q[A_W-1:W_W];
        word_q    = addr_q[W_W-1:0];
        a_ga      = (state_q == ST_BACK || state_q == ST_FREE) ? walk_q : cur_ga;
        fwd_live  = a_fwd != G_NULL;
        head_null = head_q == G_NULL;
        b_ga      = (op_q == OP_FETCH && fwd_live) ? a_fwd : head_q;
        w_next    = FILL_W'(word_q) + 1'b1;
    end

    // Next-state, table writes and response for the current state.
    always_comb begin
        state_d = state_q; head_d = head_q; walk_d = walk_q;
        rv_d = 1'b0; re_d = 1'b0; ra_d = A_NULL; rd_d = '0;
        step = 1'b0; data_we = 1'b0;
        fwd_we = 1'b0; fwd_idx = to_idx(a_ga); fwd_val = G_NULL;
        bwd_we = 1'b0; bwd_idx = to_idx(head_q); bwd_val = G_NULL;
        fill_we = 1'b0; fill_idx = to_idx(a_ga); fill_val = '0;
        nxt_we = 1'b0; nxt_idx = to_idx(a_ga); nxt_val = head_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_EXEC;
            ST_EXEC: begin
                if ((op_q == OP_ALLOC || (op_q == OP_STORE && word_q == LAST_W)) && head_null) begin
                    if (page_avail) state_d = ST_CARVE;
                    else begin state_d = ST_IDLE; rv_d = 1'b1; re_d = 1'b1; end
                end else begin
                    state_d = ST_IDLE; rv_d = 1'b1;
                    unique case (op_q)
                        OP_ALLOC: begin
                            head_d = b_nxt; bwd_we = 1'b1;
                            ra_d = {head_q, {W_W{1'b0}}};
                        end
                        OP_STORE: begin
                            data_we = 1'b1; fill_we = 1'b1;
                            if (word_q != LAST_W) begin
                                fill_val = (w_next > a_fill) ? w_next : a_fill;
                                ra_d = addr_q + 1'b1;
                            end else begin
                                fill_val = FULL; head_d = b_nxt;
                                fwd_we = 1'b1; fwd_val = head_q;
                                bwd_we = 1'b1; bwd_val = cur_ga;
                                ra_d = {head_q, {W_W{1'b0}}};
                            end
                        end
                        OP_FETCH: begin
                            rd_d = mem_rdata;
                            if (w_next < a_fill) ra_d = addr_q + 1'b1;
                            else if (word_q == LAST_W && a_fill == FULL && fwd_live && b_fill != '0)
                                ra_d = {a_fwd, {W_W{1'b0}}};
                        end
                        OP_DEL: begin
                            rv_d = 1'b0; walk_d = cur_ga; state_d = ST_BACK;
                        end
                    endcase
                end
            end
            ST_CARVE: begin
                step = 1'b1; head_d = carve_ga;
                fwd_we = 1'b1; fwd_idx = to_idx(carve_ga);
                fill_we = 1'b1; fill_idx = to_idx(carve_ga);
                nxt_we = 1'b1; nxt_idx = to_idx(carve_ga);
                if (carve_last) state_d = ST_EXEC;
            end
            ST_BACK: begin
                if (a_bwd == G_NULL) state_d = ST_FREE;
                else walk_d = a_bwd;
            end
            ST_FREE: begin
                fwd_we = 1'b1; fill_we = 1'b1; nxt_we = 1'b1; head_d = walk_q;
                if (!fwd_live) begin state_d = ST_IDLE; rv_d = 1'b1; end
                else walk_d = a_fwd;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, latched request, list head and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE; head_q <= G_NULL; walk_q <= G_NULL;
            op_q <= OP_ALLOC; addr_q <= '0; wdata_q <= '0;
            rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_addr <= A_NULL; rsp_rdata <= '0;
        end else begin
            state_q <= state_d; head_q <= head_d; walk_q <= walk_d;
            if (state_q == ST_IDLE && req_valid) begin
                op_q <= lgm_op_e'(req_op); addr_q <= req_addr; wdata_q <= req_wdata;
            end
            rsp_valid <= rv_d; rsp_err <= re_d; rsp_addr <= ra_d; rsp_rdata <= rd_d;
        end
    end

    assign req_ready = state_q == ST_IDLE;
endmodule

// File: rtl/lgm_ctrl_chk.sv
// Protocol and response checks for lgm_ctrl, attached by bind.
module lgm_ctrl_chk #(
    parameter int A_W = 10,
    parameter int W_W = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_ready,
    input logic           rsp_valid,
    input logic           rsp_err,
    input logic [A_W-1:0] rsp_addr,
    input logic           in_exec,
    input logic [1:0]     exec_op,
    input logic [A_W-1:0] exec_addr
);
    // R10: a response is a single-cycle pulse.
    p_rsp_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10: the controller is idle again when a response is presented.
    p_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

    // R9: an error response carries the null address.
    p_err_null_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (&rsp_addr));

    // R4: a store below the last word answers next cycle with address plus one.
    p_store_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && exec_op == 2'd1 && exec_addr[W_W-1:0] != '1)
        |=> (rsp_valid && !rsp_err && rsp_addr == $past(exec_addr) + 1'b1));

    // R2: a successful allocation points at word 0 of a group.
    p_alloc_word0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && exec_op == 2'd0)
        |=> (!rsp_valid || rsp_err || rsp_addr[W_W-1:0] == '0));
endmodule

bind lgm_ctrl lgm_ctrl_chk #(.A_W(A_W), .W_W(W_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_addr(rsp_addr),
    .in_exec(state_q == lgm_pkg::ST_EXEC), .exec_op(op_q), .exec_addr(addr_q)
);

// File: tb/lgm_ctrl_tb_top.sv
`timescale 1ns/1ps
// Directed bench for lgm_ctrl: one task per scenario.
module lgm_ctrl_tb_top;
    localparam logic [9:0] NULLA = 10'h3FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = '0;
    logic [9:0]  req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [9:0]  rsp_addr;
    logic [63:0] rsp_rdata;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic        r_err;
    logic [9:0]  r_addr;
    logic [63:0] r_data;
    int          r_lat, r_busy;
    logic        r_after;

    always #4 clk = ~clk;

    lgm_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_addr(rsp_addr), .rsp_rdata(rsp_rdata)
    );

    function automatic logic [63:0] pat(input int i);
        return 64'hC0DE_5A00_0000_0000 ^ (64'(i) * 64'h0001_0003_0007_000B);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one request and collect its response, latency and busy count.
    task automatic xact(input logic [1:0] op, input logic [9:0] a, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        r_lat = 0; r_busy = 0;
        do begin
            @(negedge clk);
            req_valid = 1'b0;
            r_lat++;
            if (!req_ready) r_busy++;
        end while (!rsp_valid && r_lat < 1000);
        r_err = rsp_err; r_addr = rsp_addr; r_data = rsp_rdata;
        @(negedge clk);
        r_after = rsp_valid;
    endtask

    task automatic t_reset;
        check(req_ready === 1'b1, "R1 ready", 64'(req_ready), 1);
        check(rsp_valid === 1'b0, "R1 rsp_valid", 64'(rsp_valid), 0);
    endtask

    task automatic t_first_alloc;
        xact(2'd0, '0, '0);
        check(!r_err && r_addr == 10'h000, "R2 first alloc", 64'(r_addr), 64'h000);
        check(r_lat == 31, "R3 carve latency", 64'(r_lat - 1), 30);
        check(r_busy == 30, "R10 busy during carve", 64'(r_busy), 30);
        check(r_after == 1'b0, "R10 single pulse", 64'(r_after), 0);
        xact(2'd0, '0, '0);
        check(!r_err && r_addr == 10'h008, "R2 second alloc", 64'(r_addr), 64'h008);
        check(r_lat == 2, "R3 fast latency", 64'(r_lat - 1), 1);
    endtask

    task automatic t_store_chain;
        logic [9:0] a;
        xact(2'd0, '0, '0);
        check(r_addr == 10'h010, "R2 third alloc", 64'(r_addr), 64'h010);
        a = r_addr;
        for (int i = 0; i < 10; i++) begin
            logic [9:0] exp;
            exp = (i < 7) ? 10'(16 + i + 1) : 10'(24 + i - 7);
            xact(2'd1, a, pat(i));
            if (i == 7) check(r_addr == exp && !r_err, "R5 store crosses group", 64'(r_addr), 64'(exp));
            else        check(r_addr == exp && !r_err, "R4 store next", 64'(r_addr), 64'(exp));
            a = r_addr;
        end
    endtask

    task automatic t_fetch_walk;
        logic [9:0] a;
        a = 10'h010;
        for (int i = 0; i < 10; i++) begin
            logic [9:0] exp;
            exp = (i == 9) ? NULLA : (i < 7) ? 10'(17 + i) : 10'(24 + i - 7);
            xact(2'd2, a, '0);
            check(r_data == pat(i), "R6 fetch data", r_data, pat(i));
            if (i == 9) check(r_addr == exp, "R7 fetch end null", 64'(r_addr), 64'(exp));
            else        check(r_addr == exp, "R6 fetch next", 64'(r_addr), 64'(exp));
            a = r_addr;
        end
        xact(2'd2, 10'h008, '0);
        check(r_addr == NULLA, "R7 empty group null", 64'(r_addr), 64'(NULLA));
    endtask

    task automatic t_delete;
        xact(2'd3, 10'h019, '0);
        check(!r_err && r_lat == 6, "R8 delete from mid chain", 64'(r_lat), 6);
        xact(2'd0, '0, '0);
        check(r_addr == 10'h018, "R8 last freed first", 64'(r_addr), 64'h018);
        xact(2'd0, '0, '0);
        check(r_addr == 10'h010, "R8 first freed second", 64'(r_addr), 64'h010);
    endtask

    task automatic t_exhaust;
        int ok_cnt;
        for (int i = 0; i < 7; i++) begin
            xact(2'd1, 10'(i), pat(40 + i));
            if (i == 6) check(r_addr == 10'h007, "R4 store word 6", 64'(r_addr), 64'h007);
        end
        ok_cnt = 0;
        do begin
            xact(2'd0, '0, '0);
            if (!r_err) ok_cnt++;
        end while (!r_err && ok_cnt < 200);
        check(ok_cnt == 108, "R9 allocations before exhaustion", 64'(ok_cnt), 108);
        check(r_err && r_addr == NULLA, "R9 alloc error null", 64'(r_addr), 64'(NULLA));
        check(r_lat == 2, "R3 no carve when pool empty", 64'(r_lat - 1), 1);
        xact(2'd1, 10'h007, 64'hDEAD_BEEF_0000_0007);
        check(r_err && r_addr == NULLA, "R9 store needing group fails", 64'(r_addr), 64'(NULLA));
        xact(2'd2, 10'h006, '0);
        check(r_data == pat(46), "R9 data intact", r_data, pat(46));
        check(r_addr == NULLA, "R9 word count unchanged", 64'(r_addr), 64'(NULLA));
        xact(2'd2, 10'h005, '0);
        check(r_addr == 10'h006, "R6 next within group", 64'(r_addr), 64'h006);
        xact(2'd1, 10'h008, pat(99));
        check(!r_err && r_addr == 10'h009, "R4 store without allocation", 64'(r_addr), 64'h009);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_alloc();
        t_store_chain();
        t_fetch_walk();
        t_delete();
        t_exhaust();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule